// File: doc/BRIEF.md
# Processor-Memory Handshake Controller

This block sequences one memory transfer per processor request using a four-phase request/acknowledge protocol. The processor raises a request line and, with it, a direction bit: high for a read, low for a write. The controller then walks through a fixed set of states. For a read, it enables the array, opens its output drivers, and then raises a data-ready acknowledge. For a write, it enables the array, pulses the write strobe for one cycle, and then raises a write-done acknowledge. The acknowledge stays up until the processor drops its request. One clock after that, the controller is back in idle.

Every output is decoded from the current state alone, so the block is a Moore machine. The state register is a small synchronous up-counter, and the next-state logic only ever tells it to clear, to increment, or to load a new value. The load is used only to jump from idle to the first state of a read or a write. Stepping through a sequence is an increment, and the return to idle is a clear. The data and address paths sit outside this block.

Top module: `mem_handshake_ctl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller goes to idle, and `mem_ce`, `mem_oe`, `mem_we`, `rd_ready` and `wr_done` are all 0 after that edge. This holds even when `req` is high.
- R2: In idle with `req` low, the controller stays in idle and all five outputs remain 0.
- R3: If idle sees `req`=1 with `rw`=1 (read) at a clock edge, the outputs over the next three edges are: `mem_ce` alone; then `mem_ce`+`mem_oe`; then `mem_ce`+`mem_oe`+`rd_ready`.
- R4: If idle sees `req`=1 with `rw`=0 (write) at a clock edge, the outputs over the next three edges are: `mem_ce` alone; then `mem_ce`+`mem_we`; then `mem_ce`+`wr_done`. `mem_we` is high for exactly one cycle.
- R5: In an acknowledge state (`rd_ready` or `wr_done` high), the controller holds that state for as long as `req` stays high.
- R6: At the first clock edge where an acknowledge state sees `req` low, the controller returns to idle and all outputs become 0.
- R7: `rw` is sampled only on the idle-to-transfer edge. A change of `rw` during a transfer has no effect on the outputs.
- R8: `req` is ignored in the non-acknowledge transfer states. If `req` drops before the acknowledge, the sequence still reaches its acknowledge state, and then leaves it on the next edge.
- R9: `mem_oe` and `mem_we` are never high together, and an acknowledge is never high without `mem_ce`.
- R10: A new request seen in idle, on the edge right after a return to idle, starts a new transfer on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Transfer request from the processor |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| mem_ce | output | 1 | Memory array enable |
| mem_oe | output | 1 | Memory array output enable (read) |
| mem_we | output | 1 | Memory array write strobe |
| rd_ready | output | 1 | Read data available to the processor |
| wr_done | output | 1 | Write has completed |

## Verification
The bench builds the controller with its default 4-bit state counter. That width leaves nine codes unused, but every decision the counter can make is still reachable from the ports. Those decisions are: hold in idle, load a read or a write, increment, hold in an acknowledge, clear on release, and synchronous reset. The vector walk covers both directions and long acknowledge holds. It also covers a direction flip in the middle of a transfer, an early drop of the request, and back-to-back transfers with no idle gap beyond the one required cycle. Directed cases then cover a reset held with the request high and a reset taken in the middle of a write.

// File: rtl/mem_handshake_pkg.sv
// Package: shared state width, state codes and the strobe bundle used by the
// handshake controller. The codes are chosen so that every in-sequence step is
// a +1 of the counter; only the idle exit needs a parallel load.
package mem_handshake_pkg;

    localparam int unsigned ST_W = 4;

    typedef logic [ST_W-1:0] st_t;

    localparam st_t ST_IDLE   = st_t'(0);
    localparam st_t ST_RD_EN  = st_t'(1);
    localparam st_t ST_RD_OE  = st_t'(2);
    localparam st_t ST_RD_ACK = st_t'(3);
    localparam st_t ST_WR_EN  = st_t'(4);
    localparam st_t ST_WR_WE  = st_t'(5);
    localparam st_t ST_WR_ACK = st_t'(6);

    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
        logic rd_ready;
        logic wr_done;
    } strobe_t;

endpackage

// File: rtl/mhc_state_counter.sv
// Module: mhc_state_counter
// Synchronous loadable up-counter used as the controller's state register.
// Assumes at most one of the control inputs matters per cycle; priority is
// reset, clear, load, then increment. With none asserted the value holds.
module mhc_state_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);

    // Counter register update with fixed control priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/mhc_next_ctl.sv
// Module: mhc_next_ctl
// Next-state control: turns the current state code and the processor inputs
// into clear / load / increment commands for the state counter. Assumes the
// state codes from mem_handshake_pkg; any code outside them is cleared to idle.
module mhc_next_ctl
    import mem_handshake_pkg::*;
(
    input  st_t  state,
    input  logic req,
    input  logic rw,
    output logic clr,
    output logic ld,
    output logic inc,
    output st_t  ld_val
);

    // Command decode per state.
    always_comb begin
        clr    = 1'b0;
        ld     = 1'b0;
        inc    = 1'b0;
        ld_val = rw ? ST_RD_EN : ST_WR_EN;
        unique case (state)
            ST_IDLE: begin
                ld = req;
            end
            ST_RD_EN, ST_RD_OE, ST_WR_EN, ST_WR_WE: begin
                inc = 1'b1;
            end
            ST_RD_ACK, ST_WR_ACK: begin
                clr = ~req;
            end
            default: begin
                clr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mhc_strobe_decode.sv
// Module: mhc_strobe_decode
// Moore output decode: maps a state code to the memory strobes and the two
// acknowledges. Purely combinational; assumes nothing about the inputs.
module mhc_strobe_decode
    import mem_handshake_pkg::*;
(
    input  st_t     state,
    output strobe_t strb
);

    // Per-state output table.
    always_comb begin
        strb = '0;
        unique case (state)
            ST_RD_EN:  begin strb.ce = 1'b1; end
            ST_RD_OE:  begin strb.ce = 1'b1; strb.oe = 1'b1; end
            ST_RD_ACK: begin strb.ce = 1'b1; strb.oe = 1'b1; strb.rd_ready = 1'b1; end
            ST_WR_EN:  begin strb.ce = 1'b1; end
            ST_WR_WE:  begin strb.ce = 1'b1; strb.we = 1'b1; end
            ST_WR_ACK: begin strb.ce = 1'b1; strb.wr_done = 1'b1; end
            default:   begin strb = '0; end
        endcase
    end

endmodule

// File: rtl/mem_handshake_ctl.sv
// Module: mem_handshake_ctl (top)
// Four-phase processor/memory handshake controller. A counter holds the state;
// the next-state block drives only its clear, load and increment inputs; the
// outputs depend on the state alone. Assumes req/rw are synchronous to clk.
module mem_handshake_ctl
    import mem_handshake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rw,
    output logic mem_ce,
    output logic mem_oe,
    output logic mem_we,
    output logic rd_ready,
    output logic wr_done
);

    st_t     state_q;
    st_t     ld_val;
    logic    clr;
    logic    ld;
    logic    inc;
    strobe_t strb;

    mhc_state_counter #(
        .W (ST_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .ld     (ld),
        .inc    (inc),
        .ld_val (ld_val),
        .q      (state_q)
    );

    mhc_next_ctl u_next (
        .state  (state_q),
        .req    (req),
        .rw     (rw),
        .clr    (clr),
        .ld     (ld),
        .inc    (inc),
        .ld_val (ld_val)
    );

    mhc_strobe_decode u_dec (
        .state (state_q),
        .strb  (strb)
    );

    // Drive the ports from the decoded bundle.
    always_comb begin
        mem_ce   = strb.ce;
        mem_oe   = strb.oe;
        mem_we   = strb.we;
        rd_ready = strb.rd_ready;
        wr_done  = strb.wr_done;
    end

endmodule

// File: rtl/mem_handshake_ctl_chk.sv
// Module: mem_handshake_ctl_chk
// Protocol checker bound into mem_handshake_ctl. Watches the ports and the
// state register; assumes a single clock and synchronous active-low reset.
module mem_handshake_ctl_chk
    import mem_handshake_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic mem_ce,
    input logic mem_oe,
    input logic mem_we,
    input logic rd_ready,
    input logic wr_done,
    input st_t  state
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(mem_ce || mem_oe || mem_we || rd_ready || wr_done));

    a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req) |=> (state == ST_IDLE));

    a_r3_ready_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |-> $past(mem_oe));

    a_r4_done_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_done) |-> $past(mem_we));

    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> !mem_we);

    a_r5_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && req) |=> rd_ready);

    a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && req) |=> wr_done);

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ready || wr_done) && !req) |=> !(mem_ce || rd_ready || wr_done));

    a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_oe && mem_we));

    a_r9_ack_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready || wr_done) |-> mem_ce);

endmodule

bind mem_handshake_ctl mem_handshake_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .mem_ce   (mem_ce),
    .mem_oe   (mem_oe),
    .mem_we   (mem_we),
    .rd_ready (rd_ready),
    .wr_done  (wr_done),
    .state    (state_q)
);

// File: tb/mem_handshake_ctl_bench.sv
// Bench for mem_handshake_ctl: a vector table walked cycle by cycle, then
// directed reset cases. Inputs change on the falling edge; outputs are
// compared 1 ns after the rising edge that follows.
module mem_handshake_ctl_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic req;
    logic rw;
    logic mem_ce, mem_oe, mem_we, rd_ready, wr_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mem_handshake_ctl u_mem_handshake_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .rw       (rw),
        .mem_ce   (mem_ce),
        .mem_oe   (mem_oe),
        .mem_we   (mem_we),
        .rd_ready (rd_ready),
        .wr_done  (wr_done)
    );

    // Vector: {tag[3:0], rst_n, req, rw, exp{ce,oe,we,rd_ready,wr_done}}
    localparam int NV = 30;
    localparam logic [11:0] VEC [0:NV-1] = '{
        12'b0001_0_0_0_00000, // R1 reset
        12'b0010_1_0_0_00000, // R2 idle stays
        12'b0010_1_0_1_00000, // R2 idle stays, rw high
        12'b0011_1_1_1_10000, // R3 read enable
        12'b0011_1_1_1_11000, // R3 output enable
        12'b0011_1_1_1_11010, // R3 data ready
        12'b0101_1_1_1_11010, // R5 hold
        12'b0101_1_1_1_11010, // R5 hold
        12'b0110_1_0_1_00000, // R6 release
        12'b0100_1_1_0_10000, // R4 write enable
        12'b0100_1_1_0_10100, // R4 write strobe
        12'b0100_1_1_0_10001, // R4 write done
        12'b0101_1_1_0_10001, // R5 hold
        12'b0110_1_0_0_00000, // R6 release
        12'b0011_1_1_1_10000, // R3 read starts
        12'b0111_1_1_0_11000, // R7 rw flip ignored
        12'b0111_1_1_0_11010, // R7 still a read
        12'b0110_1_0_0_00000, // R6 release
        12'b0100_1_1_0_10000, // R4 write starts
        12'b1000_1_0_0_10100, // R8 early drop ignored
        12'b1000_1_0_0_10001, // R8 ack still reached
        12'b1000_1_0_0_00000, // R8 leaves at once
        12'b0011_1_1_1_10000, // R3 read
        12'b0011_1_1_1_11000, // R3
        12'b0011_1_1_1_11010, // R3
        12'b0110_1_0_1_00000, // R6 release
        12'b1010_1_1_0_10000, // R10 immediate new write
        12'b1010_1_1_0_10100, // R10
        12'b0001_0_1_0_00000, // R1 reset mid-write
        12'b0010_1_0_0_00000  // R2 idle after reset
    };

    function automatic logic [4:0] outs();
        return {mem_ce, mem_oe, mem_we, rd_ready, wr_done};
    endfunction

    // Apply inputs at the falling edge, then check after the next rising edge.
    task automatic step(input logic r_n, input logic rq, input logic d,
                        input logic [4:0] exp, input int tag);
        @(negedge clk);
        rst_n = r_n;
        req   = rq;
        rw    = d;
        @(posedge clk);
        #1;
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL R%0d: outputs {ce,oe,we,rdy,done} = %b, expected %b",
                     tag, outs(), exp);
        end
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(8 * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req   = 1'b0;
        rw    = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:0], int'(VEC[i][11:8]));
        end

        // R1: reset held with req high keeps everything quiet
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 1'b1, 5'b00000, 1);
        end
        // R10: request already high at reset release starts on first edge
        step(1'b1, 1'b1, 1'b1, 5'b10000, 10);
        step(1'b1, 1'b1, 1'b1, 5'b11000, 3);
        step(1'b1, 1'b1, 1'b1, 5'b11010, 3);
        // R1: reset from the acknowledge state
        step(1'b0, 1'b1, 1'b1, 5'b00000, 1);
        // R4: write strobe lasts exactly one cycle
        step(1'b1, 1'b1, 1'b0, 5'b10000, 4);
        step(1'b1, 1'b1, 1'b0, 5'b10100, 4);
        step(1'b1, 1'b1, 1'b1, 5'b10001, 4);
        // R5: long hold of write done
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1, 1'b1, 5'b10001, 5);
        end
        // R6: release, then R2 idle
        step(1'b1, 1'b0, 1'b1, 5'b00000, 6);
        step(1'b1, 1'b0, 1'b1, 5'b00000, 2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule